// File: doc/BRIEF.md
# Bus Transceiver Operating-Mode Controller

This block is the digital sequencer of a single-wire bus transceiver. It decides which of four operating modes the transceiver is in (powered off, standby, normal or sleep). From that mode it derives the control levels for the analog side: transmitter enable, bus termination choice, the inhibit output that switches an external regulator, the behaviour of the receive pin and the strength of the pull on the transmit pin. It takes a supply-low flag from the power-on-reset circuit, an enable level from the host, and single-cycle wake strobes from separate detectors, one for bus activity and one for the local wake pin. It also takes the received bus bit, which it passes to the receive pin in normal mode.

Mode changes driven by the enable level are filtered. Each direction has its own counter of clock cycles, and a counter starts again from zero whenever enable reverts. When the block comes out of sleep through a wake-up, the pin setup it shows in standby tells the host which kind of wake occurred. That setup is dropped as soon as the host raises enable, so the host can drive the transmit pin without conflict while the enable filter is still running.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While `rstN` is low, or at any clock edge where `porActive` is 1, the mode becomes powered off. Mode codes on `modeOut`: 0 off, 1 standby, 2 normal, 3 sleep.
- R2: In the off mode: `txEnable`=0, `termSel`=0 (no termination), `inhOn`=0, `rxMode`=0 (released), `txPull`=0 (weak pull-down), `rxData`=1.
- R3: At the first edge where `porActive` is 0 in the off mode, the block enters standby with `rxMode`=0, `txPull`=0, `inhOn`=1 and `termSel`=1 (resistor).
- R4: A wake strobe in sleep enters standby at the next edge with `rxMode`=1 (forced low). `txPull` becomes 1 (strong) after a local wake and stays 0 after a bus wake. If both strobes arrive together, the local wake sets the pull.
- R5: In standby, wake strobes change neither the mode nor `rxMode` or `txPull`.
- R6: From standby or sleep the mode becomes normal at the edge where `enIn` has been sampled high on EN_CYC+1 consecutive edges. A low sample restarts the count.
- R7: In standby, while `enIn` is 1, `rxMode` is 0 and `txPull` is 0 in the same cycle, with no clock edge needed. Once one edge has seen `enIn` high, the stored wake setup is cleared and does not come back when `enIn` falls.
- R8: In normal: `txEnable`=1, `termSel`=1, `inhOn`=1, `rxMode`=2 (live data), and `rxData` follows `rxBus` combinationally.
- R9: Normal becomes sleep at the edge where `enIn` has been sampled low on DIS_CYC+1 consecutive edges. In sleep: `txEnable`=0, `termSel`=2 (current source), `inhOn`=0, `rxMode`=0, `txPull`=0.
- R10: In normal, a wake strobe while `enIn` is low (the disable window) enters standby with the wake setup of R4. A wake strobe while `enIn` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| porActive | input | 1 | Supply below its reset level |
| enIn | input | 1 | Host enable level |
| wakeBus | input | 1 | One-cycle strobe: bus wake detected |
| wakeLocal | input | 1 | One-cycle strobe: local pin wake detected |
| rxBus | input | 1 | Received bus bit (1 recessive) |
| modeOut | output | 2 | Current mode code |
| txEnable | output | 1 | Transmitter enable |
| termSel | output | 2 | Termination select: 0 none, 1 resistor, 2 current source |
| inhOn | output | 1 | Drive inhibit output high |
| rxMode | output | 2 | Receive pin: 0 released, 1 forced low, 2 live data |
| rxData | output | 1 | Data bit for the receive pin in live mode |
| txPull | output | 1 | Transmit pin pull-down: 0 weak, 1 strong |

## Verification
The assertions assume the wake inputs are single-cycle strobes that come only from the detectors, and that `porActive` and `enIn` are synchronous levels held across each clock edge. The stimulus changes every input only on the falling clock edge. It keeps enable high or low for runs that are long enough to cross both filter limits and short enough to interrupt them. It raises `porActive` rarely and briefly, so the random run mostly goes through full standby, normal and sleep cycles, with wakes landing in every mode, including the disable window.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_STBY  = 2'd1,
    MODE_NORM  = 2'd2,
    MODE_SLEEP = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    TERM_NONE = 2'd0,
    TERM_RES  = 2'd1,
    TERM_CSRC = 2'd2
  } term_e;

  typedef enum logic [1:0] {
    RXP_REL  = 2'd0,
    RXP_LOW  = 2'd1,
    RXP_DATA = 2'd2
  } rxpin_e;

  typedef enum logic {
    TXP_WEAK   = 1'b0,
    TXP_STRONG = 1'b1
  } txpull_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clearCfg;
    logic loadWake;
    logic wakeIsLocal;
  } ctrl_strobe_t;

endpackage

// File: rtl/xcvr_mode_fsm.sv
module xcvr_mode_fsm
  import xcvr_mode_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         porActive,
  input  logic         enIn,
  input  logic         wakeBus,
  input  logic         wakeLocal,
  input  logic         enQual,
  input  logic         disQual,
  output mode_e        mode,
  output ctrl_strobe_t strobe
);

  mode_e modeNext;
  logic  anyWake;

  assign anyWake = wakeBus | wakeLocal;

  always_comb begin
    modeNext = mode;
    strobe   = '0;
    unique case (mode)
      MODE_OFF: begin
        strobe.clearCfg = 1'b1;
        modeNext        = MODE_STBY;
      end
      MODE_STBY: begin
        // enable high drops the wake setup at once (R7)
        if (enIn) strobe.clearCfg = 1'b1;
        if (enQual) modeNext = MODE_NORM;
      end
      MODE_NORM: begin
        if (!enIn && anyWake) begin
          modeNext           = MODE_STBY;
          strobe.loadWake    = 1'b1;
          strobe.wakeIsLocal = wakeLocal;
        end else if (disQual) begin
          modeNext = MODE_SLEEP;
        end
      end
      MODE_SLEEP: begin
        if (anyWake) begin
          modeNext           = MODE_STBY;
          strobe.loadWake    = 1'b1;
          strobe.wakeIsLocal = wakeLocal;
        end else if (enQual) begin
          modeNext = MODE_NORM;
        end
      end
      default: modeNext = MODE_OFF;
    endcase
    if (porActive) begin
      modeNext        = MODE_OFF;
      strobe          = '0;
      strobe.clearCfg = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_OFF;
    else       mode <= modeNext;
  end

  // R1: supply loss forces the off mode
  a_r1_por_off: assert property (@(posedge clk) disable iff (!rstN)
    porActive |=> mode == MODE_OFF);

  // R6: normal is entered only after a qualified enable
  a_r6_norm_entry: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_NORM && $past(mode) != MODE_NORM) |-> $past(enQual));

  // R9: sleep is reached from normal only through the disable filter
  a_r9_sleep_entry: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SLEEP && $past(mode) == MODE_NORM) |-> $past(disQual));

endmodule

// File: rtl/xcvr_mode_dp.sv
module xcvr_mode_dp
  import xcvr_mode_pkg::*;
#(
  parameter int unsigned EN_CYC  = 8,
  parameter int unsigned DIS_CYC = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         porActive,
  input  logic         enIn,
  input  logic         rxBus,
  input  mode_e        mode,
  input  ctrl_strobe_t strobe,
  output logic         enQual,
  output logic         disQual,
  output logic         txEnable,
  output term_e        termSel,
  output logic         inhOn,
  output rxpin_e       rxMode,
  output logic         rxData,
  output txpull_e      txPull
);

  localparam int unsigned MAX_CYC = (EN_CYC > DIS_CYC) ? EN_CYC : DIS_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  logic [1:0] filtLevel;
  logic [1:0] filtHit;
  logic       cfgRxLow;
  logic       cfgTxStrong;

  // index 0: enable-high filter, index 1: enable-low filter
  assign filtLevel = {~enIn, enIn};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    localparam logic [CW-1:0] LIMIT = (g == 0) ? CW'(EN_CYC) : CW'(DIS_CYC);
    logic [CW-1:0] runCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          runCnt <= '0;
      else if (porActive || !filtLevel[g]) runCnt <= '0;
      else if (runCnt != LIMIT)           runCnt <= runCnt + 1'b1;
    end

    assign filtHit[g] = filtLevel[g] && (runCnt == LIMIT);
  end

  assign enQual  = filtHit[0];
  assign disQual = filtHit[1];

  // wake setup shown in standby
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgRxLow    <= 1'b0;
      cfgTxStrong <= 1'b0;
    end else if (strobe.loadWake) begin
      cfgRxLow    <= 1'b1;
      cfgTxStrong <= strobe.wakeIsLocal;
    end else if (strobe.clearCfg) begin
      cfgRxLow    <= 1'b0;
      cfgTxStrong <= 1'b0;
    end
  end

  always_comb begin
    txEnable = 1'b0;
    termSel  = TERM_NONE;
    inhOn    = 1'b0;
    rxMode   = RXP_REL;
    rxData   = 1'b1;
    txPull   = TXP_WEAK;
    unique case (mode)
      MODE_STBY: begin
        termSel = TERM_RES;
        inhOn   = 1'b1;
        if (!enIn && cfgRxLow)    rxMode = RXP_LOW;
        if (!enIn && cfgTxStrong) txPull = TXP_STRONG;
      end
      MODE_NORM: begin
        txEnable = 1'b1;
        termSel  = TERM_RES;
        inhOn    = 1'b1;
        rxMode   = RXP_DATA;
        rxData   = rxBus;
      end
      MODE_SLEEP: termSel = TERM_CSRC;
      default: ;
    endcase
  end

  // R4: a strong pull only appears together with a forced-low receive pin
  a_r4_strong_needs_low: assert property (@(posedge clk) disable iff (!rstN)
    txPull == TXP_STRONG |-> rxMode == RXP_LOW);

  // R5: wakes in standby leave the stored setup untouched
  a_r5_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_STBY && !enIn && !porActive) |=> $stable({cfgRxLow, cfgTxStrong}));

  // R6: a qualified enable needs enable high on the previous edge as well
  a_r6_qual_history: assert property (@(posedge clk) disable iff (!rstN)
    enQual |-> $past(enIn));

  // R9: a qualified disable needs enable low on the previous edge as well
  a_r9_qual_history: assert property (@(posedge clk) disable iff (!rstN)
    disQual |-> !$past(enIn));

endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xcvr_mode_pkg::*;
#(
  parameter int unsigned EN_CYC  = 8,
  parameter int unsigned DIS_CYC = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       porActive,
  input  logic       enIn,
  input  logic       wakeBus,
  input  logic       wakeLocal,
  input  logic       rxBus,
  output logic [1:0] modeOut,
  output logic       txEnable,
  output logic [1:0] termSel,
  output logic       inhOn,
  output logic [1:0] rxMode,
  output logic       rxData,
  output logic       txPull
);

  mode_e        mode;
  ctrl_strobe_t strobe;
  logic         enQual;
  logic         disQual;
  term_e        termE;
  rxpin_e       rxE;
  txpull_e      txE;

  xcvr_mode_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .porActive (porActive),
    .enIn      (enIn),
    .wakeBus   (wakeBus),
    .wakeLocal (wakeLocal),
    .enQual    (enQual),
    .disQual   (disQual),
    .mode      (mode),
    .strobe    (strobe)
  );

  xcvr_mode_dp #(
    .EN_CYC  (EN_CYC),
    .DIS_CYC (DIS_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .porActive (porActive),
    .enIn      (enIn),
    .rxBus     (rxBus),
    .mode      (mode),
    .strobe    (strobe),
    .enQual    (enQual),
    .disQual   (disQual),
    .txEnable  (txEnable),
    .termSel   (termE),
    .inhOn     (inhOn),
    .rxMode    (rxE),
    .rxData    (rxData),
    .txPull    (txE)
  );

  assign modeOut = mode;
  assign termSel = termE;
  assign rxMode  = rxE;
  assign txPull  = txE;

endmodule

// File: tb/xcvr_mode_ctrl_test.sv
`timescale 1ns/1ps
module xcvr_mode_ctrl_test;

  localparam int EN_CYC  = 8;
  localparam int DIS_CYC = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic porActive = 1'b1;
  logic enIn = 1'b0;
  logic wakeBus = 1'b0;
  logic wakeLocal = 1'b0;
  logic rxBus = 1'b1;
  logic [1:0] modeOut, termSel, rxMode;
  logic txEnable, inhOn, rxData, txPull;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  // reference state
  int mState = 0;
  int mEnCnt = 0;
  int mDisCnt = 0;
  bit mRxLow = 0;
  bit mTxStrong = 0;

  always #2 clk = ~clk;

  xcvr_mode_ctrl #(.EN_CYC(EN_CYC), .DIS_CYC(DIS_CYC)) uut (
    .clk(clk), .rstN(rstN), .porActive(porActive), .enIn(enIn),
    .wakeBus(wakeBus), .wakeLocal(wakeLocal), .rxBus(rxBus),
    .modeOut(modeOut), .txEnable(txEnable), .termSel(termSel),
    .inhOn(inhOn), .rxMode(rxMode), .rxData(rxData), .txPull(txPull)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic modelEdge();
    bit w, eq, dq, ld, loc, clr;
    int ns;
    if (!rstN) begin
      mState = 0; mEnCnt = 0; mDisCnt = 0; mRxLow = 0; mTxStrong = 0;
      return;
    end
    w  = wakeBus | wakeLocal;
    eq = enIn && (mEnCnt == EN_CYC);
    dq = !enIn && (mDisCnt == DIS_CYC);
    ns = mState; ld = 0; clr = 0; loc = wakeLocal;
    if (porActive) begin ns = 0; clr = 1; end
    else case (mState)
      0: begin clr = 1; ns = 1; end
      1: begin if (enIn) clr = 1; if (eq) ns = 2; end
      2: if (!enIn && w) begin ns = 1; ld = 1; end else if (dq) ns = 3;
      default: if (w) begin ns = 1; ld = 1; end else if (eq) ns = 2;
    endcase
    if (ld) begin mRxLow = 1; mTxStrong = loc; end
    else if (clr) begin mRxLow = 0; mTxStrong = 0; end
    mState = ns;
    if (porActive || !enIn) mEnCnt = 0; else if (mEnCnt < EN_CYC) mEnCnt++;
    if (porActive || enIn) mDisCnt = 0; else if (mDisCnt < DIS_CYC) mDisCnt++;
  endtask

  task automatic compareAll(string tag);
    logic [7:0] eTx, eTerm, eInh, eRx, eRd, ePull;
    eTx = 0; eTerm = 0; eInh = 0; eRx = 0; eRd = 1; ePull = 0;
    case (mState)
      1: begin
        eTerm = 1; eInh = 1;
        if (!enIn && mRxLow) eRx = 1;
        if (!enIn && mTxStrong) ePull = 1;
      end
      2: begin eTx = 1; eTerm = 1; eInh = 1; eRx = 2; eRd = {7'd0, rxBus}; end
      3: eTerm = 2;
      default: ;
    endcase
    chk(tag, "mode", {6'd0, modeOut}, 8'(mState));
    chk(tag, "txEnable", {7'd0, txEnable}, eTx);
    chk(tag, "termSel", {6'd0, termSel}, eTerm);
    chk(tag, "inhOn", {7'd0, inhOn}, eInh);
    chk(tag, "rxMode", {6'd0, rxMode}, eRx);
    chk(tag, "rxData", {7'd0, rxData}, eRd);
    chk(tag, "txPull", {7'd0, txPull}, ePull);
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    wakeBus = 1'b0;
    wakeLocal = 1'b0;
    compareAll(tag);
  endtask

  task automatic goNormal();
    enIn = 1'b1;
    repeat (EN_CYC) cyc("R6");
    chk("R6", "mode before filter end", {6'd0, modeOut}, (modeOut == 2'd3) ? 8'd3 : 8'd1);
    cyc("R6");
    chk("R6", "mode after filter end", {6'd0, modeOut}, 8'd2);
  endtask

  task automatic goSleep();
    enIn = 1'b0;
    repeat (DIS_CYC) cyc("R9");
    chk("R9", "mode before filter end", {6'd0, modeOut}, 8'd2);
    cyc("R9");
    chk("R9", "mode after filter end", {6'd0, modeOut}, 8'd3);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual running expected finished");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'h1ace_5eed));
    @(negedge clk);
    cyc("R2");
    chk("R2", "reset mode", {6'd0, modeOut}, 8'd0);
    rstN = 1'b1;
    repeat (3) cyc("R1");
    chk("R1", "held off by supply flag", {6'd0, modeOut}, 8'd0);
    chk("R2", "off termination", {6'd0, termSel}, 8'd0);
    porActive = 1'b0;
    cyc("R3");
    chk("R3", "standby after supply up", {6'd0, modeOut}, 8'd1);
    chk("R3", "standby rx released", {6'd0, rxMode}, 8'd0);

    wakeLocal = 1'b1; cyc("R5");
    wakeBus = 1'b1;   cyc("R5");
    chk("R5", "standby ignores wakes", {7'd0, txPull}, 8'd0);
    chk("R5", "standby mode kept", {6'd0, modeOut}, 8'd1);

    enIn = 1'b1;
    repeat (EN_CYC) cyc("R6");
    enIn = 1'b0; cyc("R6");
    enIn = 1'b1;
    repeat (EN_CYC) cyc("R6");
    chk("R6", "restarted filter not done", {6'd0, modeOut}, 8'd1);
    cyc("R6");
    chk("R6", "normal after full run", {6'd0, modeOut}, 8'd2);

    for (int i = 0; i < 4; i++) begin
      rxBus = i[0];
      #1 chk("R8", "rxData follows bus", {7'd0, rxData}, {7'd0, rxBus});
      cyc("R8");
    end
    rxBus = 1'b1;
    wakeLocal = 1'b1; cyc("R10");
    chk("R10", "wake with enable high ignored", {6'd0, modeOut}, 8'd2);

    goSleep();
    wakeLocal = 1'b1; cyc("R4");
    chk("R4", "local wake rx low", {6'd0, rxMode}, 8'd1);
    chk("R4", "local wake strong pull", {7'd0, txPull}, 8'd1);
    enIn = 1'b1;
    #1 compareAll("R7");
    chk("R7", "pull released at once", {7'd0, txPull}, 8'd0);
    cyc("R7");
    enIn = 1'b0; cyc("R7");
    chk("R7", "stays released", {6'd0, rxMode}, 8'd0);

    goNormal();
    enIn = 1'b0;
    repeat (3) cyc("R10");
    wakeBus = 1'b1; cyc("R10");
    chk("R10", "disable window wake", {6'd0, modeOut}, 8'd1);
    chk("R10", "bus wake weak pull", {7'd0, txPull}, 8'd0);
    chk("R10", "bus wake rx low", {6'd0, rxMode}, 8'd1);

    goNormal();
    goSleep();
    wakeBus = 1'b1; cyc("R4");
    chk("R4", "bus wake weak pull", {7'd0, txPull}, 8'd0);
    goNormal();
    goSleep();
    wakeBus = 1'b1; wakeLocal = 1'b1; cyc("R4");
    chk("R4", "both wakes strong pull", {7'd0, txPull}, 8'd1);

    goNormal();
    porActive = 1'b1; cyc("R1");
    chk("R1", "supply loss from normal", {6'd0, modeOut}, 8'd0);
    porActive = 1'b0; cyc("R3");

    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(9) == 0) enIn = ~enIn;
      if ($urandom_range(29) == 0) wakeBus = 1'b1;
      if ($urandom_range(29) == 0) wakeLocal = 1'b1;
      porActive = ($urandom_range(399) == 0);
      rxBus = $urandom_range(1);
      cyc("RAND");
    end

    done = 1'b1;
    finishRun();
  end

endmodule